// File: doc/BRIEF.md
# Integer ALU with condition codes

This block is the integer execute stage of a 32-bit load/store processor. Each cycle it can accept one decoded arithmetic-format instruction word together with the two source values read from the register file and the current four condition flags (negative, zero, overflow, carry). It selects the second operand from either the register value or a sign-extended immediate held in the instruction. It then computes the result and, for the flag-setting forms, a fresh set of flags. Everything is captured in one output register stage, so results appear exactly one cycle after the instruction is presented.

Supported operations are add, subtract, and, or, xor, and the three logic forms that invert the second operand. Add-with-carry folds the incoming carry into the second operand. Each of these also has a flag-setting twin. There are also logical left, logical right and arithmetic right shifts. Any other opcode, or an instruction word that is not of the arithmetic format, is flagged as illegal and writes nothing. A destination of register 0 never produces a register write.

Flags are carried on a 4-bit bus ordered {N, Z, V, C}, bit 3 down to bit 0.

Top module: `cc_exec_unit`

## Requirements
- R1: While reset is held and in the cycle after it, out_valid, wr_en, flags_wr and illegal are 0 and result is 0.
- R2: An instruction is legal only when instr[31:30] = 2'b10 and the opcode instr[24:19] is one of 0x00..0x08, 0x10..0x18, 0x25, 0x26 or 0x27. Any other word with in_valid raises illegal, drives wr_en = 0 and flags_wr = 0, and leaves flags_out equal to flags_in.
- R3: When instr[13] is 1, the second operand is instr[12:0] sign-extended to 32 bits. Otherwise it is src_b.
- R4: Opcodes 0/0x10 add, 4/0x14 subtract (src_a minus operand), 1/0x11 and, 2/0x12 or, 3/0x13 xor, 5/0x15 and-not, 6/0x16 or-not and 7/0x17 xnor. For the last three, the second operand is bit-inverted first.
- R5: Opcodes 8/0x18 add src_a to (operand + incoming C), modulo 2^32.
- R6: Flag-setting forms (0x10..0x18) assert flags_wr and set N = result[31] and Z = (result == 0). The logic forms set V = C = 0. All other legal forms drive flags_wr = 0 and pass flags_in to flags_out.
- R7: For the add forms, V is signed overflow of src_a + operand', where operand' is the carry-incremented operand for 0x18. C is the unsigned carry out of that 32-bit sum.
- R8: For subtract with flags, V is set when the operand signs differ and the result sign differs from src_a's. C is set when src_a < operand as unsigned values (borrow).
- R9: Opcodes 0x25, 0x26 and 0x27 shift src_a left logically, right logically and right arithmetically (sign fill). The shift amount is the low 5 bits of the second operand.
- R10: wr_en is 1 only for a valid, legal instruction whose destination field instr[29:25] is non-zero. wr_dst carries that field.
- R11: All outputs register the instruction presented one cycle earlier. out_valid follows in_valid, and with in_valid low, wr_en, flags_wr and illegal are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Registered copy of in_valid |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register write enable |
| wr_dst | output | 5 | Destination register number |
| flags_out | output | 4 | Flags after the operation {N,Z,V,C} |
| flags_wr | output | 1 | Flags were recomputed by this instruction |
| illegal | output | 1 | Instruction word not accepted |

## Verification
There is no state beyond the single output register, so a decode or datapath fault shows on result, flags_out or the enables in the very cycle after the offending instruction. The sweep presents every one of the 64 opcode values with register and immediate operands. Operand pairs are chosen to land on carry, borrow, overflow, zero and sign boundaries, and the incoming carry is varied. A wrongly decoded slot, a missing operand inversion, a stale carry fold or a mis-wired flag therefore diverges at the ports one cycle later.

// File: rtl/cc_exec_pkg.sv
package cc_exec_pkg;
    localparam int XLEN      = 32;
    localparam int OPW       = 6;
    localparam int REGW      = 5;
    localparam int IMMW      = 13;
    localparam int SHW       = $clog2(XLEN);
    localparam int NFLAG     = 4;
    localparam int FN        = 3;
    localparam int FZ        = 2;
    localparam int FV        = 1;
    localparam int FC        = 0;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLL, K_SRL, K_SRA
    } kind_e;

    typedef struct packed {
        logic            legal;
        kind_e           kind;
        logic            inv_b;
        logic            use_carry;
        logic            set_cc;
        logic            is_shift;
        logic            use_imm;
        logic [REGW-1:0] dst;
        logic [XLEN-1:0] imm;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  result;
        logic             wr_en;
        logic [REGW-1:0]  dst;
        logic [NFLAG-1:0] flags;
        logic             flags_wr;
        logic             illegal;
    } stage_t;
endpackage

// File: rtl/cc_exec_decode.sv
module cc_exec_decode
    import cc_exec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [OPW-1:0] op;
    logic           unused_rs1;

    assign op         = instr[24:19];
    assign unused_rs1 = ^instr[18:14];

    always_comb begin
        ctrl           = '0;
        ctrl.kind      = K_ADD;
        ctrl.use_imm   = instr[13];
        ctrl.dst       = instr[29:25];
        ctrl.imm       = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
        if (instr[31:30] == 2'b10) begin
            if (op[5] == 1'b0 && op[3:0] <= 4'd8) begin
                ctrl.legal  = 1'b1;
                ctrl.set_cc = op[4];
                unique case (op[3:0])
                    4'd0: ctrl.kind = K_ADD;
                    4'd1: ctrl.kind = K_AND;
                    4'd2: ctrl.kind = K_OR;
                    4'd3: ctrl.kind = K_XOR;
                    4'd4: ctrl.kind = K_SUB;
                    4'd5: begin ctrl.kind = K_AND; ctrl.inv_b = 1'b1; end
                    4'd6: begin ctrl.kind = K_OR;  ctrl.inv_b = 1'b1; end
                    4'd7: begin ctrl.kind = K_XOR; ctrl.inv_b = 1'b1; end
                    default: begin ctrl.kind = K_ADD; ctrl.use_carry = 1'b1; end
                endcase
            end else if (op == 6'h25 || op == 6'h26 || op == 6'h27) begin
                ctrl.legal    = 1'b1;
                ctrl.is_shift = 1'b1;
                ctrl.kind     = (op == 6'h25) ? K_SLL : (op == 6'h26) ? K_SRL : K_SRA;
            end
        end
    end
endmodule

// File: rtl/cc_exec_arith.sv
module cc_exec_arith
    import cc_exec_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  kind_e           kind,
    input  logic            inv_b,
    input  logic            use_carry,
    input  logic            carry_in,
    output logic [XLEN-1:0] res,
    output logic            v_out,
    output logic            c_out
);
    localparam int MSB = XLEN - 1;
    logic [XLEN-1:0] b_inv;
    logic [XLEN-1:0] b_add;
    logic            a31, b31, r31;

    assign b_inv = inv_b ? ~b : b;
    assign b_add = b_inv + {{(XLEN-1){1'b0}}, use_carry & carry_in};

    always_comb begin
        res = '0;
        unique case (kind)
            K_ADD:   res = a + b_add;
            K_SUB:   res = a - b_inv;
            K_AND:   res = a & b_inv;
            K_OR:    res = a | b_inv;
            K_XOR:   res = a ^ b_inv;
            default: res = '0;
        endcase
        a31   = a[MSB];
        b31   = (kind == K_ADD) ? b_add[MSB] : b_inv[MSB];
        r31   = res[MSB];
        v_out = 1'b0;
        c_out = 1'b0;
        if (kind == K_ADD) begin
            v_out = (a31 & b31 & ~r31) | (~a31 & ~b31 & r31);
            c_out = (a31 & b31) | (~r31 & (a31 | b31));
        end else if (kind == K_SUB) begin
            v_out = (a31 & ~b31 & ~r31) | (~a31 & b31 & r31);
            c_out = (~a31 & b31) | (r31 & (~a31 | b31));
        end
    end
endmodule

// File: rtl/cc_exec_shift.sv
module cc_exec_shift
    import cc_exec_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    input  kind_e           kind,
    output logic [XLEN-1:0] res
);
    logic [2*XLEN-1:0] wide;

    assign wide = {{XLEN{(kind == K_SRA) & a[XLEN-1]}}, a} >> amt;

    always_comb begin
        if (kind == K_SLL) res = a << amt;
        else               res = wide[XLEN-1:0];
    end
endmodule

// File: rtl/cc_exec_unit.sv
module cc_exec_unit
    import cc_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [NFLAG-1:0]  flags_in,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic [REGW-1:0]   wr_dst,
    output logic [NFLAG-1:0]  flags_out,
    output logic              flags_wr,
    output logic              illegal
);
    ctrl_t           ctrl;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] arith_res, shift_res;
    logic            arith_v, arith_c;
    stage_t          stage_d, stage_q;

    cc_exec_decode u_dec (.instr(instr), .ctrl(ctrl));

    assign opnd_b = ctrl.use_imm ? ctrl.imm : src_b;

    cc_exec_arith u_arith (
        .a(src_a), .b(opnd_b), .kind(ctrl.kind), .inv_b(ctrl.inv_b),
        .use_carry(ctrl.use_carry), .carry_in(flags_in[FC]),
        .res(arith_res), .v_out(arith_v), .c_out(arith_c)
    );

    cc_exec_shift u_shift (
        .a(src_a), .amt(opnd_b[SHW-1:0]), .kind(ctrl.kind), .res(shift_res)
    );

    always_comb begin
        stage_d          = '0;
        stage_d.valid    = in_valid;
        stage_d.dst      = ctrl.dst;
        stage_d.flags    = flags_in;
        if (ctrl.legal) begin
            stage_d.result = ctrl.is_shift ? shift_res : arith_res;
            if (in_valid) stage_d.wr_en = (ctrl.dst != '0);
            if (ctrl.set_cc) begin
                stage_d.flags_wr  = in_valid;
                stage_d.flags[FN] = stage_d.result[XLEN-1];
                stage_d.flags[FZ] = (stage_d.result == '0);
                stage_d.flags[FV] = arith_v;
                stage_d.flags[FC] = arith_c;
            end
        end else begin
            stage_d.illegal = in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign result    = stage_q.result;
    assign wr_en     = stage_q.wr_en;
    assign wr_dst    = stage_q.dst;
    assign flags_out = stage_q.flags;
    assign flags_wr  = stage_q.flags_wr;
    assign illegal   = stage_q.illegal;

    a_r2_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !flags_wr));
    a_r10_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_dst != '0));
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !flags_wr && !illegal));
    a_r6_zn_match: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr |-> (flags_out[FZ] == (result == '0) && flags_out[FN] == result[XLEN-1]));
    a_r9_sra_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl.legal && ctrl.kind == K_SRA && src_a[XLEN-1]) |=> result[XLEN-1]);
endmodule

// File: tb/cc_exec_unit_tb_top.sv
module cc_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, src_a = '0, src_b = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid, wr_en, flags_wr, illegal;
    logic [31:0] result;
    logic [4:0]  wr_dst;
    logic [3:0]  flags_out;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cc_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .wr_dst(wr_dst),
        .flags_out(flags_out), .flags_wr(flags_wr), .illegal(illegal)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int op);
        if (op == 4 || op == 20) return "R8";
        if (op == 8 || op == 24) return "R5";
        if (op >= 16 && op <= 24) return "R6";
        if (op >= 37 && op <= 39) return "R9";
        if (op <= 7) return "R4";
        return "R2";
    endfunction

    // Expected {legal, result, flags_wr, flags}
    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] fi, output bit lg, output logic [31:0] r,
                         output bit fw, output logic [3:0] fo);
        logic [32:0] s;
        int base;
        bit v, c;
        lg = 1; fw = 0; fo = fi; r = 0; v = 0; c = 0;
        base = op % 16;
        if (op < 32 && base <= 8) begin
            case (base)
                0: begin s = {1'b0,a} + {1'b0,b}; r = s[31:0]; c = s[32];
                         v = (a[31] == b[31]) && (r[31] != a[31]); end
                4: begin r = a - b; c = (a < b);
                         v = (a[31] != b[31]) && (r[31] != a[31]); end
                1: r = a & b;
                2: r = a | b;
                3: r = a ^ b;
                5: r = a & ~b;
                6: r = a | ~b;
                7: r = ~(a ^ b);
                default: begin
                    logic [31:0] bb;
                    bb = b + {31'd0, fi[0]};
                    s = {1'b0,a} + {1'b0,bb}; r = s[31:0]; c = s[32];
                    v = (a[31] == bb[31]) && (r[31] != a[31]);
                end
            endcase
            if (op >= 16) begin
                fw = 1; fo = {r[31], r == 0, v, c};
            end
        end else if (op == 37) r = a << b[4:0];
        else if (op == 38) r = a >> b[4:0];
        else if (op == 39) r = $unsigned($signed(a) >>> b[4:0]);
        else lg = 0;
    endtask

    task automatic run_one(int op, logic [4:0] rd, logic imm, logic [12:0] i13,
                           logic [31:0] a, logic [31:0] b, logic [3:0] fi, string extra);
        bit lg, fw;
        logic [31:0] r, be;
        logic [3:0] fo;
        string t;
        @(negedge clk);
        in_valid = 1; src_a = a; src_b = b; flags_in = fi;
        instr = {2'b10, rd, op[5:0], 5'd3, imm, i13};
        be = imm ? {{19{i13[12]}}, i13} : b;
        model(op, a, be, fi, lg, r, fw, fo);
        @(negedge clk);
        t = {tag_of(op), extra};
        if (imm) t = {t, " R3"};
        check({t, " illegal"}, {63'd0, illegal}, {63'd0, !lg});
        check({t, " R10 wr_en"}, {63'd0, wr_en}, {63'd0, lg && rd != 0});
        check({t, " R6 flags"}, {59'd0, fw, flags_out}, {59'd0, fw, fo});
        if (lg) check({t, " result"}, {32'd0, result}, {32'd0, r});
        if (lg) check({t, " R10 dst"}, {59'd0, wr_dst}, {59'd0, rd});
    endtask

    logic [31:0] pa [10] = '{32'h0, 32'h7fffffff, 32'h80000000, 32'hffffffff,
                             32'h00000001, 32'h12345678, 32'h80000000, 32'h7fffffff,
                             32'hdeadbeef, 32'h0000ffff};
    logic [31:0] pb [10] = '{32'h0, 32'h00000001, 32'h80000000, 32'hffffffff,
                             32'h00000001, 32'h0000001f, 32'h00000001, 32'hffffffff,
                             32'h00000024, 32'hffff0001};

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {60'd0, out_valid, wr_en, flags_wr, illegal}, 64'd0);
        check("R1 reset result", {32'd0, result}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", {60'd0, out_valid, wr_en, flags_wr, illegal}, 64'd0);
        for (int op = 0; op < 64; op++)
            for (int p = 0; p < 10; p++)
                for (int cin = 0; cin < 2; cin++)
                    run_one(op, 5'(p + 1), 1'b0, 13'd0, pa[p], pb[p],
                            {p[0], p[1], p[2], cin[0]}, " R7");
        for (int op = 0; op < 64; op++) begin
            run_one(op, 5'd9, 1'b1, 13'h1fff, 32'h00000005, 32'h0, 4'b0001, "");
            run_one(op, 5'd9, 1'b1, 13'h0fff, 32'h80000001, 32'hffffffff, 4'b0000, "");
            run_one(op, 5'd0, 1'b0, 13'd0, 32'h5, 32'h5, 4'b1111, " R10");
        end
        // Non-arithmetic format is illegal
        @(negedge clk);
        in_valid = 1; instr = {2'b11, 5'd4, 6'd0, 19'd0}; flags_in = 4'b1010;
        @(negedge clk);
        check("R2 format", {58'd0, illegal, wr_en, flags_wr, flags_out}, {58'd0, 3'b100, 4'b1010});
        // Idle cycle
        in_valid = 0; instr = {2'b10, 5'd4, 6'h10, 19'd0};
        @(negedge clk);
        check("R11 idle", {60'd0, out_valid, wr_en, flags_wr, illegal}, 64'd0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (150000) @(posedge clk); n_checks++; n_fail++;
                  $display("FAIL watchdog R11 actual=hung expected=done"); end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule